// File: doc/BRIEF.md
# Peripheral Idle and Soft-Reset Controller

This block sits beside a peripheral such as a serial port and looks after its system housekeeping. A small 16-bit register bus reaches two locations. One is a configuration word that selects the idle policy, enables wakeup and enables automatic gating of the interface clock. The other is a read-only status word that reports whether a software-started module reset has finished.

Software starts a module reset by writing a 1 into a self-clearing bit of the configuration word. A reset sequencer then holds `mod_rst_o` high for a fixed number of cycles and reports completion through the status word. The sequencer has three states: `RS_READY`, `RS_HOLD` and `RS_RELEASE`. A start request moves it from `RS_READY` to `RS_HOLD`. When the hold count expires it moves from `RS_HOLD` to `RS_RELEASE`. It always moves from `RS_RELEASE` back to `RS_READY` on the next cycle.

A system power manager raises `idle_req_i`, and the block answers on `idle_ack_o` according to one of four policies. Two of those policies depend on the module's `mod_busy_i` signal. The idle state machine has two states, `IS_RUN` and `IS_ACK`. It moves from `IS_RUN` to `IS_ACK` when the selected policy grants the request. It moves from `IS_ACK` to `IS_RUN` when the request is withdrawn, when the policy forbids idling, or when a smart policy sees the module busy. A separate wakeup flag is raised by module events while the block is acknowledged idle. Clock gating is modelled as the enable output `clk_en_o`.

Top module: `periph_pm_ctrl`

## Requirements
- R1: Address 0 holds the configuration word, and every field resets to 0.
  - Bit 0 is auto-gate.
  - Bit 2 is wake-enable.
  - Bits 4:3 are the idle policy.
  - Bits 15:5 and bit 1 always read 0.
  - A write is a cycle with `bus_sel_i=1` and `bus_wr_i=1`. It updates the word at the clock edge that ends that cycle.
  - `bus_rdata_o` shows the addressed word combinationally.
- R2: A write to address 0 with bit 1 set starts a soft reset. From the next cycle, `mod_rst_o` is 1 for exactly 8 consecutive cycles.
- R3: Address 1 is the status word, and bits 15:1 read 0.
  - Bit 0 reads 1 after the global reset.
  - Bit 0 reads 0 from the start of a soft reset until one cycle after `mod_rst_o` falls.
  - Bit 0 reads 1 from then on.
- R4: A soft reset leaves the configuration word unchanged. A new soft-reset write while a soft reset is in progress is ignored and does not extend the pulse.
- R5: Policy 0 (force) grants the request regardless of `mod_busy_i`.
  - `idle_ack_o` rises the cycle after `idle_req_i` is seen high.
  - `idle_ack_o` falls the cycle after `idle_req_i` is seen low.
- R6: Policy 1 (never) keeps `idle_ack_o` at 0 and drops an existing acknowledge on the next cycle.
- R7: Policy 2 (smart) raises `idle_ack_o` the cycle after a cycle with `idle_req_i=1` and `mod_busy_i=0`. It drops the acknowledge the cycle after `mod_busy_i=1` or `idle_req_i=0`.
- R8: Policy 3 (smart with wakeup) acknowledges as in R7.
  - With wake-enable 1, a `mod_event_i` pulse seen while `idle_ack_o=1` raises `wake_req_o` on the next cycle.
  - `wake_req_o` then stays 1, even if the acknowledge drops, until the cycle after `idle_req_i` is seen low.
  - `wake_req_o` never rises under any other policy or with wake-enable 0.
- R9: With auto-gate 0, `clk_en_o` is 1. With auto-gate 1, `clk_en_o` equals `bus_sel_i`, so the clock is enabled only during register accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | 1 | 0 selects configuration, 1 selects status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed word |
| mod_busy_i | input | 1 | Module reports internal activity |
| mod_event_i | input | 1 | Module event that may cause wakeup |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_ack_o | output | 1 | Idle acknowledge |
| wake_req_o | output | 1 | Wakeup request |
| clk_en_o | output | 1 | Interface clock enable |
| mod_rst_o | output | 1 | Module reset, active high |

## Verification
The assertions assume that the power manager holds `idle_req_i` steady between clock edges. They also assume that `mod_busy_i` and `mod_event_i` are synchronous to `clk_i`, and that bus writes last a single cycle. The bench changes every input just after a rising edge and pulses accesses for one cycle only. It changes the idle policy only while no request is pending, apart from the retry of a soft reset in the middle of a pulse, which deliberately probes R4.

// File: rtl/periph_pm_pkg.sv
package periph_pm_pkg;

    localparam int unsigned REG_W = 16;

    typedef enum logic [1:0] {
        POL_FORCE      = 2'd0,
        POL_NEVER      = 2'd1,
        POL_SMART      = 2'd2,
        POL_SMART_WAKE = 2'd3
    } idle_pol_e;

    typedef struct packed {
        idle_pol_e pol;
        logic      wake_en;
        logic      auto_gate;
    } pm_cfg_t;

    typedef enum logic [1:0] {
        RS_READY,
        RS_HOLD,
        RS_RELEASE
    } rst_state_e;

    typedef enum logic {
        IS_RUN,
        IS_ACK
    } idle_state_e;

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import periph_pm_pkg::*;
#(
    parameter int unsigned DW = REG_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          done_i,
    output logic [DW-1:0] rdata_o,
    output pm_cfg_t       cfg_o,
    output logic          sreset_o
);

    localparam int unsigned CFG_BITS = $bits(pm_cfg_t) + 1;

    pm_cfg_t cfg_q;
    logic    cfg_wr;
    logic    unused_wbits;

    assign cfg_wr       = sel_i && wr_i && !addr_i;
    assign sreset_o     = cfg_wr && wdata_i[1];
    assign unused_wbits = ^wdata_i[DW-1:CFG_BITS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.auto_gate <= wdata_i[0];
            cfg_q.wake_en   <= wdata_i[2];
            cfg_q.pol       <= idle_pol_e'(wdata_i[4:3]);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i) begin
            rdata_o[0] = done_i;
        end else begin
            rdata_o[0]   = cfg_q.auto_gate;
            rdata_o[2]   = cfg_q.wake_en;
            rdata_o[4:3] = cfg_q.pol;
        end
    end

    assign cfg_o = cfg_q;

    p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wr |=> $stable(cfg_q));

endmodule

// File: rtl/pm_rst_seq.sv
module pm_rst_seq
    import periph_pm_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic mod_rst_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RS_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_READY: begin
                if (start_i) begin
                    state_d = RS_HOLD;
                    cnt_d   = '0;
                end
            end
            RS_HOLD: begin
                if (cnt_q == CNT_W'(RST_CYCLES - 1)) begin
                    state_d = RS_RELEASE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            RS_RELEASE: state_d = RS_READY;
            default:    state_d = RS_READY;
        endcase
    end

    always_comb begin
        mod_rst_o = (state_q == RS_HOLD);
        done_o    = (state_q == RS_READY);
    end

    logic [CNT_W:0] len_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        len_q <= '0;
        else if (mod_rst_o) len_q <= len_q + 1'b1;
        else                len_q <= '0;
    end

    p_rst_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mod_rst_o) |-> (len_q == (CNT_W+1)'(RST_CYCLES)));
    p_rst_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mod_rst_o |-> (len_q < (CNT_W+1)'(RST_CYCLES)));
    p_done_after_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mod_rst_o) |=> done_o);
    p_busy_not_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mod_rst_o |-> !done_o);

endmodule

// File: rtl/pm_idle_fsm.sv
module pm_idle_fsm
    import periph_pm_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  idle_pol_e pol_i,
    input  logic      wake_en_i,
    input  logic      req_i,
    input  logic      busy_i,
    input  logic      event_i,
    output logic      ack_o,
    output logic      wake_o
);

    idle_state_e state_q, state_d;
    logic        wake_q, wake_d;
    logic        smart;

    assign smart = (pol_i == POL_SMART) || (pol_i == POL_SMART_WAKE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= IS_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IS_RUN: begin
                if (req_i && ((pol_i == POL_FORCE) || (smart && !busy_i)))
                    state_d = IS_ACK;
            end
            IS_ACK: begin
                if (!req_i || (pol_i == POL_NEVER) || (smart && busy_i))
                    state_d = IS_RUN;
            end
            default: state_d = IS_RUN;
        endcase
    end

    always_comb begin
        wake_d = wake_q;
        if (!req_i) begin
            wake_d = 1'b0;
        end else if ((state_q == IS_ACK) && (pol_i == POL_SMART_WAKE) &&
                     wake_en_i && event_i) begin
            wake_d = 1'b1;
        end
    end

    always_comb begin
        ack_o  = (state_q == IS_ACK);
        wake_o = wake_q;
    end

    p_force_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_i == POL_FORCE && req_i) |=> ack_o);
    p_never_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_i == POL_NEVER) |=> !ack_o);
    p_smart_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smart && ack_o && (busy_i || !req_i)) |=> !ack_o);
    p_wake_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !wake_o);
    p_wake_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_o) |-> $past(ack_o && wake_en_i && (pol_i == POL_SMART_WAKE)));

endmodule

// File: rtl/periph_pm_ctrl.sv
module periph_pm_ctrl
    import periph_pm_pkg::*;
#(
    parameter int unsigned DW         = REG_W,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic          bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          mod_busy_i,
    input  logic          mod_event_i,
    input  logic          idle_req_i,
    output logic          idle_ack_o,
    output logic          wake_req_o,
    output logic          clk_en_o,
    output logic          mod_rst_o
);

    pm_cfg_t cfg;
    logic    sreset;
    logic    done;

    pm_cfg_regs #(.DW(DW)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .done_i   (done),
        .rdata_o  (bus_rdata_o),
        .cfg_o    (cfg),
        .sreset_o (sreset)
    );

    pm_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (sreset),
        .mod_rst_o (mod_rst_o),
        .done_o    (done)
    );

    pm_idle_fsm u_idle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pol_i     (cfg.pol),
        .wake_en_i (cfg.wake_en),
        .req_i     (idle_req_i),
        .busy_i    (mod_busy_i),
        .event_i   (mod_event_i),
        .ack_o     (idle_ack_o),
        .wake_o    (wake_req_o)
    );

    assign clk_en_o = !cfg.auto_gate || bus_sel_i;

    p_gate_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clk_en_o) |-> (!bus_sel_i && (bus_rdata_o[0] || bus_addr_i)));

endmodule

// File: tb/periph_pm_ctrl_tb.sv
module periph_pm_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy = 1'b0, evt = 1'b0, req = 1'b0;
    logic        ack, wake, clk_en, mrst;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [15:0] val;
        string       req;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    periph_pm_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .mod_busy_i(busy), .mod_event_i(evt), .idle_req_i(req),
        .idle_ack_o(ack), .wake_req_o(wake), .clk_en_o(clk_en),
        .mod_rst_o(mrst)
    );

    // kinds: 0 rdata, 1 ack, 2 wake, 3 clk_en, 4 module reset
    task automatic expect_item(input int kind, input logic [15:0] v, input string r);
        item_t it;
        it.kind = kind; it.val = v; it.req = r;
        exp_q.push_back(it);
    endtask

    // monitor: compares every queued expectation mid-cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = {15'b0, ack};
                2:       act = {15'b0, wake};
                3:       act = {15'b0, clk_en};
                default: act = {15'b0, mrst};
            endcase
            n_chk++;
            if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        cyc();
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic bus_read(input logic a, input logic [15:0] e, input string r);
        cyc();
        sel = 1'b1; addr = a;
        expect_item(0, e, r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        bus_read(1'b0, 16'h0000, "R1");
        expect_item(1, 16'd0, "R5");
        expect_item(4, 16'd0, "R2");
        expect_item(3, 16'd1, "R9");
        bus_read(1'b1, 16'h0001, "R3");

        // field layout, reserved bits read zero, auto-gate
        bus_write(1'b0, 16'hFFFD);
        cyc();
        expect_item(3, 16'd0, "R9");
        expect_item(4, 16'd0, "R2");
        bus_read(1'b0, 16'h001D, "R1");
        expect_item(3, 16'd1, "R9");
        bus_write(1'b0, 16'h0000);
        cyc();
        expect_item(3, 16'd1, "R9");

        // soft reset: policy 2 plus start bit
        bus_write(1'b0, 16'h0012);
        for (int k = 1; k <= 8; k++) begin
            cyc();
            expect_item(4, 16'd1, "R2");
            if (k == 2) begin sel = 1'b1; addr = 1'b1; expect_item(0, 16'h0000, "R3"); end
            if (k == 3) begin sel = 1'b1; addr = 1'b0; expect_item(0, 16'h0010, "R4"); end
            if (k == 5) begin sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 16'h0012; end
        end
        cyc();
        expect_item(4, 16'd0, "R2");
        sel = 1'b1; addr = 1'b1; expect_item(0, 16'h0000, "R3");
        cyc();
        expect_item(4, 16'd0, "R4");
        sel = 1'b1; addr = 1'b1; expect_item(0, 16'h0001, "R3");
        bus_read(1'b0, 16'h0010, "R4");

        // policy 0: force
        bus_write(1'b0, 16'h0000);
        cyc(); req = 1'b1; busy = 1'b1; expect_item(1, 16'd0, "R5");
        cyc(); expect_item(1, 16'd1, "R5");
        cyc(); req = 1'b0; expect_item(1, 16'd1, "R5");
        cyc(); expect_item(1, 16'd0, "R5"); busy = 1'b0;

        // policy 1: never
        bus_write(1'b0, 16'h0008);
        cyc(); req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cyc(); expect_item(1, 16'd0, "R6");
        end
        req = 1'b0;

        // policy 2: smart
        bus_write(1'b0, 16'h0010);
        cyc(); req = 1'b1; busy = 1'b1; expect_item(1, 16'd0, "R7");
        cyc(); expect_item(1, 16'd0, "R7"); busy = 1'b0;
        cyc(); expect_item(1, 16'd1, "R7"); busy = 1'b1;
        cyc(); expect_item(1, 16'd0, "R7"); busy = 1'b0;
        cyc(); expect_item(1, 16'd1, "R7"); req = 1'b0;
        cyc(); expect_item(1, 16'd0, "R7");

        // policy 3 with wake-enable
        bus_write(1'b0, 16'h001C);
        cyc(); req = 1'b1; expect_item(1, 16'd0, "R8"); expect_item(2, 16'd0, "R8");
        cyc(); expect_item(1, 16'd1, "R8"); expect_item(2, 16'd0, "R8"); evt = 1'b1;
        cyc(); evt = 1'b0; busy = 1'b1; expect_item(2, 16'd1, "R8");
        cyc(); expect_item(1, 16'd0, "R8"); expect_item(2, 16'd1, "R8");
        cyc(); req = 1'b0; expect_item(2, 16'd1, "R8");
        cyc(); expect_item(2, 16'd0, "R8"); busy = 1'b0;

        // policy 3 without wake-enable: no wakeup
        bus_write(1'b0, 16'h0018);
        cyc(); req = 1'b1;
        cyc(); expect_item(1, 16'd1, "R8"); evt = 1'b1;
        cyc(); evt = 1'b0; expect_item(2, 16'd0, "R8");
        cyc(); req = 1'b0; expect_item(2, 16'd0, "R8");

        // policy 2 with wake-enable: no wakeup
        bus_write(1'b0, 16'h0014);
        cyc(); req = 1'b1;
        cyc(); expect_item(1, 16'd1, "R7"); evt = 1'b1;
        cyc(); evt = 1'b0; expect_item(2, 16'd0, "R8");
        cyc(); req = 1'b0;
        cyc();
        cyc();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule